// File: doc/BRIEF.md
# Excitation-Proportional Output Scaler

This block drives an emulated displacement-sensor output for hardware-in-the-loop rigs. Each signed excitation sample arriving from the converter front end is multiplied by a host-written scale coefficient. The product is shifted right arithmetically and clamped to the output width, and the result is presented as the next converter output sample. The host folds sensitivity, simulated position and a power-of-two constant into the coefficient. The shift selected here removes that constant again, so one integer multiplier covers both small and large output-to-excitation ratios.

The datapath has two register stages that advance on every input strobe. A capture stage holds the newest sample together with the coefficient and shift mode in force when it arrived. At the same time, the output stage turns the previously captured sample into an output word. Acquisition of sample n+1 therefore overlaps the update for sample n, and each output trails its input by exactly one sample period.

Top module: `exc_scaler`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_sample` is 0. The coefficient register resets to 0.
- R2: `out_valid` is high for exactly the one clock after an `exc_valid` cycle, and only if a sample was already held at that cycle. The first strobe after reset produces no output.
- R3: With `shift_sel` = 0, the output is the product of the held sample and its coefficient, divided by 2^14 and rounded toward minus infinity.
- R4: With `shift_sel` = 1, the divisor is 2^15 instead.
- R5: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R6: Negative products round downward. For example, sample -1 with coefficient 1 gives -1, and sample 1 with coefficient 1 gives 0.
- R7: A coefficient written with `scale_wr` applies only to samples captured on later strobes. A write in the same cycle as `exc_valid` does not affect the sample captured in that cycle, and a sample already held keeps its coefficient.
- R8: Between strobes, `out_sample` holds its value and `out_valid` stays 0, even while coefficient writes occur.
- R9: `shift_sel` is sampled together with the sample at capture. A change made while a sample is held does not alter that sample's output.
- R10: The output presented on the strobe that captures sample n+1 is computed from sample n, which gives a latency of one sample period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Strobe marking a new excitation sample |
| exc_sample | input | 16 | Signed excitation sample |
| scale_wr | input | 1 | Coefficient write strobe |
| scale_in | input | 16 | Signed coefficient value |
| shift_sel | input | 1 | 0: shift by 14, 1: shift by 15 |
| out_valid | output | 1 | One-clock pulse marking a new output sample |
| out_sample | output | 16 | Signed, saturated output sample |

## Verification
The bench drives extreme sample and coefficient pairs to both rails. A datapath that wrapped instead of clamping would return a small value of the wrong sign. It also feeds tiny negative products, which a truncating shift would round to 0 instead of -1. Coefficient writes are placed in the same cycle as a strobe and while a sample is held. A design that applied the coefficient at output time, or let a write reach the sample being captured, would produce the wrong product on exactly one sample. The first strobe after reset, the shift-mode change during a held sample, and idle coefficient writes check for spurious valid pulses and for outputs that move between strobes.

// File: rtl/exc_scaler_pkg.sv
package exc_scaler_pkg;

    typedef enum logic {
        SHIFT_NARROW = 1'b0,
        SHIFT_WIDE   = 1'b1
    } shift_mode_e;

endpackage

// File: rtl/scl_coef_reg.sv
module scl_coef_reg #(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic signed [CW-1:0] din,
    output logic signed [CW-1:0] coef
);
    typedef struct packed {
        logic signed [CW-1:0] coef;
    } coef_state_t;

    coef_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.coef = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coef = st_q.coef;

endmodule

// File: rtl/scl_capture.sv
module scl_capture
    import exc_scaler_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic signed [DW-1:0] sample_in,
    input  logic signed [CW-1:0] coef_in,
    input  logic                 mode_in,
    output logic signed [DW-1:0] held_sample,
    output logic signed [CW-1:0] held_coef,
    output shift_mode_e          held_mode,
    output logic                 held_full
);
    typedef struct packed {
        logic signed [DW-1:0] sample;
        logic signed [CW-1:0] coef;
        shift_mode_e          mode;
        logic                 full;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.sample = sample_in;
            st_d.coef   = coef_in;
            st_d.mode   = shift_mode_e'(mode_in);
            st_d.full   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_sample = st_q.sample;
    assign held_coef   = st_q.coef;
    assign held_mode   = st_q.mode;
    assign held_full   = st_q.full;

    // R7: the coefficient bound to a held sample changes only on a capture
    p_coef_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(held_coef));
    // R9: the shift mode bound to a held sample changes only on a capture
    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(held_mode));
    // R2: a capture always leaves a sample held
    p_full_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> held_full);

endmodule

// File: rtl/scl_mult_sat.sv
module scl_mult_sat
    import exc_scaler_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int SHIFT_LO = 14,
    parameter int SHIFT_HI = 15
) (
    input  logic signed [DW-1:0] sample,
    input  logic signed [CW-1:0] coef,
    input  shift_mode_e          mode,
    output logic signed [DW-1:0] result
);
    localparam int PW  = DW + CW;
    localparam int SHW = $clog2(SHIFT_HI + 1);
    localparam logic signed [PW-1:0] OUT_MAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] OUT_MIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic        [SHW-1:0] shamt;

    always_comb begin
        shamt  = (mode == SHIFT_WIDE) ? SHW'(SHIFT_HI) : SHW'(SHIFT_LO);
        prod   = PW'(sample) * PW'(coef);
        scaled = prod >>> shamt;
        if (scaled > OUT_MAX)      result = OUT_MAX[DW-1:0];
        else if (scaled < OUT_MIN) result = OUT_MIN[DW-1:0];
        else                       result = scaled[DW-1:0];
    end

endmodule

// File: rtl/exc_scaler.sv
module exc_scaler
    import exc_scaler_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int SHIFT_LO = 14,
    parameter int SHIFT_HI = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_valid,
    input  logic signed [DW-1:0] exc_sample,
    input  logic                 scale_wr,
    input  logic signed [CW-1:0] scale_in,
    input  logic                 shift_sel,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);
    localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [CW-1:0] C_MIN = {1'b1, {(CW-1){1'b0}}};

    typedef struct packed {
        logic                 valid;
        logic signed [DW-1:0] data;
    } out_state_t;

    logic signed [CW-1:0] coef_cur;
    logic signed [DW-1:0] held_sample;
    logic signed [CW-1:0] held_coef;
    shift_mode_e          held_mode;
    logic                 held_full;
    logic signed [DW-1:0] next_word;

    out_state_t st_d, st_q;

    scl_coef_reg #(.CW(CW)) u_coef (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (scale_wr),
        .din  (scale_in),
        .coef (coef_cur)
    );

    scl_capture #(.DW(DW), .CW(CW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (exc_valid),
        .sample_in  (exc_sample),
        .coef_in    (coef_cur),
        .mode_in    (shift_sel),
        .held_sample(held_sample),
        .held_coef  (held_coef),
        .held_mode  (held_mode),
        .held_full  (held_full)
    );

    scl_mult_sat #(.DW(DW), .CW(CW), .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI)) u_mul (
        .sample(held_sample),
        .coef  (held_coef),
        .mode  (held_mode),
        .result(next_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (exc_valid && held_full) begin
            st_d.valid = 1'b1;
            st_d.data  = next_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_sample = st_q.data;

    // R2: an output pulse is always one clock after an input strobe
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(exc_valid));
    // R8: with no strobe, the output word holds and no pulse appears
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |=> ($stable(out_sample) && !out_valid));
    // R3: a zero coefficient on the held sample yields a zero output
    p_zero_coef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && held_full && held_coef == '0) |=> (out_sample == '0));
    // R5: the most negative pair in narrow mode clamps to the upper rail
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && held_full && held_sample == S_MIN && held_coef == C_MIN
         && held_mode == SHIFT_NARROW) |=> (out_sample == S_MAX));

endmodule

// File: tb/sim_exc_scaler.sv
module sim_exc_scaler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_valid = 1'b0;
    logic signed [15:0] exc_sample = '0;
    logic scale_wr = 1'b0;
    logic signed [15:0] scale_in = '0;
    logic shift_sel = 1'b0;
    logic out_valid;
    logic signed [15:0] out_sample;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // spec model state
    int m_coef;
    int m_s, m_k, m_sh;
    bit m_full;

    always #2 clk = ~clk;

    exc_scaler u0 (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_sample(exc_sample),
        .scale_wr(scale_wr), .scale_in(scale_in), .shift_sel(shift_sel),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int expect_word(int s, int k, int sh);
        longint p = longint'(s) * longint'(k);
        longint d = longint'(1) << sh;
        longint q;
        if (p >= 0) q = p / d;
        else        q = -((-p + d - 1) / d);
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exc_valid = 1'b0; scale_wr = 1'b0; shift_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_coef = 0; m_full = 1'b0; m_s = 0; m_k = 0; m_sh = 14;
    endtask

    task automatic write_coef(int v);
        @(negedge clk);
        scale_wr = 1'b1; scale_in = 16'(v);
        @(negedge clk);
        scale_wr = 1'b0;
        m_coef = v;
    endtask

    // strobe one sample, optionally writing a coefficient in the same cycle
    task automatic push(int s, bit wr, int wv, string req);
        bit ev;
        int ew;
        @(negedge clk);
        exc_valid = 1'b1; exc_sample = 16'(s);
        scale_wr = wr; scale_in = 16'(wv);
        ev = m_full;
        ew = expect_word(m_s, m_k, m_sh);
        m_s = s; m_k = m_coef; m_sh = shift_sel ? 15 : 14; m_full = 1'b1;
        if (wr) m_coef = wv;
        @(negedge clk);
        exc_valid = 1'b0; scale_wr = 1'b0;
        check({req, " valid"}, int'(out_valid), int'(ev));
        if (ev) check({req, " data"}, int'(out_sample), ew);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_sample), 0);
        do_reset();
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_sample), 0);
    endtask

    task automatic t_first();
        do_reset();
        write_coef(16384);
        push(500, 1'b0, 0, "R2 first strobe");
        @(negedge clk);
        check("R2 no late pulse", int'(out_valid), 0);
    endtask

    task automatic t_basic();
        do_reset();
        write_coef(16384);
        push(1000, 1'b0, 0, "R3 load");
        push(-3000, 1'b0, 0, "R10 unity");
        write_coef(8192);
        push(7, 1'b0, 0, "R3 neg unity");
        push(0, 1'b0, 0, "R3 half");
        write_coef(-16384);
        push(1234, 1'b0, 0, "R3 zero");
        push(0, 1'b0, 0, "R3 inverted");
    endtask

    task automatic t_wide();
        do_reset();
        write_coef(16384);
        shift_sel = 1'b1;
        push(2000, 1'b0, 0, "R4 load");
        push(-2001, 1'b0, 0, "R4 half");
        push(0, 1'b0, 0, "R4 half neg");
        shift_sel = 1'b0;
    endtask

    task automatic t_sat();
        do_reset();
        write_coef(32767);
        push(32767, 1'b0, 0, "R5 load");
        push(-32768, 1'b0, 0, "R5 upper rail");
        write_coef(-32768);
        push(-32768, 1'b0, 0, "R5 lower rail");
        push(0, 1'b0, 0, "R5 max neg pair");
    endtask

    task automatic t_floor();
        do_reset();
        write_coef(1);
        push(-1, 1'b0, 0, "R6 load");
        push(1, 1'b0, 0, "R6 minus one");
        push(-16384, 1'b0, 0, "R6 plus small");
        push(0, 1'b0, 0, "R6 exact");
    endtask

    task automatic t_coef_swap();
        do_reset();
        write_coef(16384);
        push(100, 1'b0, 0, "R7 load");
        push(200, 1'b1, 32767, "R7 same-cycle write");
        push(300, 1'b0, 0, "R7 old coef kept");
        push(0, 1'b0, 0, "R7 new coef");
    endtask

    task automatic t_idle_hold();
        logic signed [15:0] keep;
        do_reset();
        write_coef(16384);
        push(4321, 1'b0, 0, "R8 load");
        push(0, 1'b0, 0, "R8 emit");
        keep = out_sample;
        write_coef(-5);
        write_coef(999);
        check("R8 idle valid", int'(out_valid), 0);
        check("R8 idle data", int'(out_sample), int'(keep));
    endtask

    task automatic t_mode_capture();
        do_reset();
        write_coef(16384);
        shift_sel = 1'b0;
        push(3000, 1'b0, 0, "R9 load");
        shift_sel = 1'b1;
        push(3000, 1'b0, 0, "R9 narrow kept");
        push(0, 1'b0, 0, "R9 wide applied");
        shift_sel = 1'b0;
    endtask

    initial begin
        t_reset();
        t_first();
        t_basic();
        t_wide();
        t_sat();
        t_floor();
        t_coef_swap();
        t_idle_hold();
        t_mode_capture();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule